// File: doc/BRIEF.md
# Scanned Seven-Segment Panel Frame Sniffer

This block listens, without driving anything, to the twelve lines of a multiplexed front panel: eight segment lines and four active-high select lines. Three selects scan numeric digits. The fourth lights a row of eight status LEDs, and each of its segment bits is one LED. The block follows the panel's own scan. It synchronises every line and waits until a select has held steady for a set number of clocks. It then takes the segment byte sampled in the middle of that steady run. The four slots must arrive in scan order, starting at select 0. When the last slot arrives, the block publishes them together as one frame.

Whenever a frame is published, `frame_valid` pulses for one clock. A published frame comes with a per-digit character code and a flag that shows whether it differs from the frame before it. Out-of-order or overlapping selects throw away the partial frame and increment an error count. A long silence on the select lines ends any partial frame and marks the panel as blank.

Top module: `disp_frame_sniffer`

## Requirements
- R1: After reset, `frame_valid`, `frame_changed`, `blank`, `err_count` and `frame_seg` are all zero.
- R2: A select value counts as qualified once it has been seen, after synchronisation, for STABLE_CLKS consecutive clocks. Select 0, then 1, 2 and 3, each qualified in turn, publish a frame in which slot k occupies `frame_seg[8k+7:8k]`. At that point `frame_valid` is high for exactly one clock.
- R3: The segment byte stored for a slot is the one present STABLE_CLKS/2 clocks into the steady select run. Patterns shown only at the beginning or at the end of the select window do not reach the frame.
- R4: A select pulse shorter than STABLE_CLKS clocks is ignored. It stores nothing and raises no error.
- R5: During a frame, if a qualified single select is not the next one expected, the partial frame is dropped and `err_count` rises by one. No frame is published until a fresh select 0 starts a new one.
- R6: During a frame, a qualified select value with two or more bits set drops the partial frame and raises `err_count` by one.
- R7: While no frame is in progress, qualified selects 1 to 3 are ignored, with no error.
- R8: If all selects stay low for TIMEOUT_CLKS clocks, any partial frame is dropped and `blank` goes to 1. `blank` returns to 0 when the next frame is published.
- R9: `digit_code[4k+3:4k]` decodes slot k (k = 0..2), with segment bit 0..6 = a..g and bit 7 (decimal point) ignored. The codes are:
  - 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F give 0 to 9.
  - 0x00 gives 10 (blank).
  - 0x79 gives 11 (E), 0x71 gives 12 (F), 0x76 gives 13 (H) and 0x40 gives 14 (minus).
  - Any other pattern gives 15.
- R10: At each publish, `frame_changed` is set to whether the new frame differs from the frame previously held (zero after reset), and it holds that value until the next publish.
- R11: `led_state` equals the slot 3 byte of the published frame, bit for bit.
- R12: `err_count` saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_in | input | 8 | Segment lines, asynchronous |
| sel_in | input | 4 | Digit-select lines, active high, asynchronous |
| frame_valid | output | 1 | One-clock strobe on frame publish |
| frame_changed | output | 1 | Published frame differs from the previous one |
| frame_seg | output | 32 | Published frame, slot k in bits 8k+7:8k |
| led_state | output | 8 | Status LED states (slot 3) |
| digit_code | output | 12 | Character code per numeric digit, 4 bits each |
| blank | output | 1 | Scan timeout seen since the last frame |
| err_count | output | ERR_W | Saturating count of dropped frames |

## Verification
The bench builds the block with STABLE_CLKS = 8 and TIMEOUT_CLKS = 64. With these values a full scan takes about sixty clocks, a timeout is reached after a short idle stretch, and a glitch of two clocks falls well inside the filter. With ERR_W = 2, saturation of the error count takes only a handful of bad frames. Because frames are so short, every one of the 256 segment values can be passed through the decoder on two digit positions, while the mid-window sampling, the order faults and the overlap faults are each driven in their own scans.

// File: rtl/disp_frame_sniffer.sv
module disp_frame_sniffer #(
  parameter int STABLE_CLKS  = 16,
  parameter int TIMEOUT_CLKS = 500000,
  parameter int ERR_W        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           seg_in,
  input  logic [3:0]           sel_in,
  output logic                 frame_valid,
  output logic                 frame_changed,
  output logic [31:0]          frame_seg,
  output logic [7:0]           led_state,
  output logic [11:0]          digit_code,
  output logic                 blank,
  output logic [ERR_W-1:0]     err_count
);
  localparam int SEG_W  = 8;
  localparam int SLOTS  = 4;
  localparam int DIGITS = SLOTS - 1;
  localparam int CNT_W  = $clog2(STABLE_CLKS + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CLKS + 1);
  localparam int MID    = STABLE_CLKS / 2;
  localparam int IDX_W  = $clog2(SLOTS);

  logic [SEG_W-1:0] seg_m, seg_s, samp;
  logic [SLOTS-1:0] sel_m, sel_s, sel_d;
  logic [CNT_W-1:0] run;
  logic [TO_W-1:0]  idle;
  logic [SLOTS-1:0][SEG_W-1:0] slot_buf;
  logic             in_frame;
  logic [IDX_W-1:0] want, idx;
  logic             steady, single, take, qual, timeout;
  logic [SLOTS*SEG_W-1:0] next_frame;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seg_m <= '0; seg_s <= '0;
      sel_m <= '0; sel_s <= '0; sel_d <= '0;
    end else begin
      seg_m <= seg_in; seg_s <= seg_m;
      sel_m <= sel_in; sel_s <= sel_m; sel_d <= sel_s;
    end

  assign steady = (sel_s == sel_d) && (sel_s != '0);
  assign single = ((sel_s & (sel_s - 1'b1)) == '0);
  assign take   = steady && (run == CNT_W'(MID));
  assign qual   = steady && (run == CNT_W'(STABLE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       run <= '0;
    else if (sel_s != sel_d)          run <= '0;
    else if (run != CNT_W'(STABLE_CLKS)) run <= run + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     samp <= '0;
    else if (take)  samp <= seg_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           idle <= '0;
    else if (sel_s != '0)                 idle <= '0;
    else if (idle != TO_W'(TIMEOUT_CLKS)) idle <= idle + 1'b1;

  assign timeout = (sel_s == '0) && (idle == TO_W'(TIMEOUT_CLKS - 1));

  always_comb begin
    idx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (sel_s[i]) idx = IDX_W'(i);
  end

  assign next_frame = {samp, slot_buf[2], slot_buf[1], slot_buf[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_frame      <= 1'b0;
      want          <= '0;
      slot_buf      <= '0;
      frame_valid   <= 1'b0;
      frame_changed <= 1'b0;
      frame_seg     <= '0;
      blank         <= 1'b0;
      err_count     <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (timeout) begin
        in_frame <= 1'b0;
        blank    <= 1'b1;
      end else if (qual) begin
        if (in_frame && single && idx == want) begin
          slot_buf[idx] <= samp;
          if (idx == IDX_W'(SLOTS - 1)) begin
            in_frame      <= 1'b0;
            frame_seg     <= next_frame;
            frame_changed <= (next_frame != frame_seg);
            frame_valid   <= 1'b1;
            blank         <= 1'b0;
          end else begin
            want <= want + 1'b1;
          end
        end else if (in_frame) begin
          in_frame <= 1'b0;
          if (err_count != '1) err_count <= err_count + 1'b1;
        end else if (single && idx == '0) begin
          slot_buf[0] <= samp;
          in_frame    <= 1'b1;
          want        <= IDX_W'(1);
        end
      end
    end

  function automatic logic [3:0] seg2code(input logic [SEG_W-1:0] p);
    case (p[6:0])
      7'h3F: seg2code = 4'd0;
      7'h06: seg2code = 4'd1;
      7'h5B: seg2code = 4'd2;
      7'h4F: seg2code = 4'd3;
      7'h66: seg2code = 4'd4;
      7'h6D: seg2code = 4'd5;
      7'h7D: seg2code = 4'd6;
      7'h07: seg2code = 4'd7;
      7'h7F: seg2code = 4'd8;
      7'h6F: seg2code = 4'd9;
      7'h00: seg2code = 4'd10;
      7'h79: seg2code = 4'd11;
      7'h71: seg2code = 4'd12;
      7'h76: seg2code = 4'd13;
      7'h40: seg2code = 4'd14;
      default: seg2code = 4'd15;
    endcase
  endfunction

  for (genvar d = 0; d < DIGITS; d++) begin : g_dec
    assign digit_code[4*d +: 4] = seg2code(frame_seg[SEG_W*d +: SEG_W]);
  end

  assign led_state = frame_seg[SEG_W*(SLOTS-1) +: SEG_W];
endmodule

// File: rtl/disp_frame_sniffer_chk.sv
module disp_frame_sniffer_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic             frame_changed,
  input logic [31:0]      frame_seg,
  input logic [7:0]       led_state,
  input logic             blank,
  input logic [ERR_W-1:0] err_count
);
  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R2
  atomic_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_seg) |-> frame_valid);

  // R8
  blank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank) |-> frame_valid);

  // R8
  publish_unblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !blank);

  // R10
  changed_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_changed == (frame_seg != $past(frame_seg))));

  // R10
  changed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(frame_changed));

  // R12
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_count) |-> (err_count == $past(err_count) + 1'b1));

  // R11
  led_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_state == frame_seg[31:24]);
endmodule

bind disp_frame_sniffer disp_frame_sniffer_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
  .frame_changed(frame_changed), .frame_seg(frame_seg),
  .led_state(led_state), .blank(blank), .err_count(err_count)
);

// File: tb/disp_frame_sniffer_test.sv
module disp_frame_sniffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int STABLE     = 8;
  localparam int TMO        = 64;
  localparam int EW         = 2;
  localparam int WIN        = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] seg_in = '0;
  logic [3:0] sel_in = '0;
  logic frame_valid, frame_changed, blank;
  logic [31:0] frame_seg;
  logic [7:0] led_state;
  logic [11:0] digit_code;
  logic [EW-1:0] err_count;

  int compared = 0, mismatched = 0;
  int nvalid = 0, cyc = 0;
  logic prev_valid = 1'b0;
  logic [31:0] cap_seg;
  logic cap_chg;
  logic [11:0] cap_code;
  logic [7:0] cap_led;
  logic [6:0] pat [15];

  disp_frame_sniffer #(.STABLE_CLKS(STABLE), .TIMEOUT_CLKS(TMO), .ERR_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .seg_in(seg_in), .sel_in(sel_in),
    .frame_valid(frame_valid), .frame_changed(frame_changed),
    .frame_seg(frame_seg), .led_state(led_state), .digit_code(digit_code),
    .blank(blank), .err_count(err_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && frame_valid) begin
      nvalid++;
      cap_seg = frame_seg; cap_chg = frame_changed;
      cap_code = digit_code; cap_led = led_state;
      check(!prev_valid, "R2 strobe width", 2, 1);
    end
    prev_valid = frame_valid;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [3:0] exp_code(input logic [7:0] p);
    for (int i = 0; i < 15; i++) if (p[6:0] == pat[i]) return 4'(i);
    return 4'd15;
  endfunction

  task automatic idle(input int n);
    sel_in = '0;
    repeat (n) @(negedge clk);
  endtask

  // hold a select value; edge cycles optionally show a ghost pattern (R3)
  task automatic slot(input logic [3:0] s, input logic [7:0] p, input bit ghost);
    for (int c = 0; c < WIN; c++) begin
      sel_in = s;
      seg_in = (ghost && (c < 2 || c >= WIN-2)) ? ~p : p;
      @(negedge clk);
    end
    idle(2);
  endtask

  task automatic scan(input logic [7:0] p0, p1, p2, p3, input bit ghost);
    slot(4'b0001, p0, ghost);
    slot(4'b0010, p1, ghost);
    slot(4'b0100, p2, ghost);
    slot(4'b1000, p3, ghost);
  endtask

  initial begin
    int n0;
    logic [EW-1:0] e0;
    pat = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,7'h7F,7'h6F,
            7'h00,7'h79,7'h71,7'h76,7'h40};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(frame_valid == 0 && frame_changed == 0 && blank == 0, "R1 flags",
          {frame_valid, frame_changed, blank}, 0);
    check(frame_seg == 0 && err_count == 0, "R1 frame/err", frame_seg, 0);
    rst_n = 1'b1;
    idle(4);

    // R2 R11 basic frame
    n0 = nvalid;
    scan(8'h11, 8'h22, 8'h33, 8'hA5, 0);
    check(nvalid == n0 + 1, "R2 one frame", nvalid - n0, 1);
    check(cap_seg == 32'hA5332211, "R2 slot order", cap_seg, 32'hA5332211);
    check(cap_led == 8'hA5, "R11 led_state", cap_led, 8'hA5);
    check(cap_chg == 1, "R10 first frame changed", cap_chg, 1);

    // R3 ghosting at window edges
    scan(8'h3F, 8'h06, 8'h5B, 8'h0F, 1);
    check(cap_seg == 32'h0F5B063F, "R3 mid-window sample", cap_seg, 32'h0F5B063F);

    // R10 identical frame
    scan(8'h3F, 8'h06, 8'h5B, 8'h0F, 0);
    check(cap_chg == 0, "R10 repeat unchanged", cap_chg, 0);

    // R4 short glitch on select 2 inside a scan
    e0 = err_count; n0 = nvalid;
    slot(4'b0001, 8'h66, 0);
    sel_in = 4'b0100; seg_in = 8'hFF; repeat (2) @(negedge clk);
    idle(2);
    slot(4'b0010, 8'h6D, 0); slot(4'b0100, 8'h7D, 0); slot(4'b1000, 8'h01, 0);
    check(err_count == e0, "R4 glitch no error", err_count, e0);
    check(nvalid == n0 + 1 && cap_seg == 32'h017D6D66, "R4 glitch ignored", cap_seg, 32'h017D6D66);

    // R5 out-of-order, then R7 idle selects ignored
    e0 = err_count; n0 = nvalid;
    slot(4'b0001, 8'h07, 0); slot(4'b0100, 8'h7F, 0);
    check(err_count == e0 + 1, "R5 skip counted", err_count, e0 + 1);
    slot(4'b1000, 8'h12, 0);
    check(err_count == e0 + 1, "R7 idle select ignored", err_count, e0 + 1);
    check(nvalid == n0, "R5 no publish", nvalid - n0, 0);

    // R6 overlapping selects
    slot(4'b0001, 8'h07, 0); slot(4'b0011, 8'h7F, 0);
    slot(4'b0100, 8'h6F, 0); slot(4'b1000, 8'h34, 0);
    check(err_count == e0 + 2, "R6 overlap counted", err_count, e0 + 2);
    check(nvalid == n0, "R6 no publish", nvalid - n0, 0);

    // R8 timeout
    slot(4'b0001, 8'h3F, 0); slot(4'b0010, 8'h3F, 0);
    idle(TMO + 16);
    check(blank == 1, "R8 blank set", blank, 1);
    slot(4'b0100, 8'h3F, 0); slot(4'b1000, 8'h3F, 0);
    check(nvalid == n0 && err_count == e0 + 2, "R8 partial dropped", nvalid - n0, 0);
    scan(8'h79, 8'h71, 8'h76, 8'h40, 0);
    check(blank == 0 && nvalid == n0 + 1, "R8 blank cleared", blank, 0);
    check(cap_code == 12'hDCB, "R9 letters", cap_code, 12'hDCB);

    // R12 saturation
    for (int k = 0; k < 5; k++) begin
      slot(4'b0001, 8'h00, 0); slot(4'b1000, 8'h00, 0);
    end
    check(err_count == '1, "R12 saturate", err_count, 3);

    // R9 R10 sweep over every segment value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] a, b;
      logic [11:0] ec;
      a = 8'(v); b = 8'(v * 37 + 5);
      scan(a, 8'h6F, b, ~a, 0);
      ec = {exp_code(b), 4'd9, exp_code(a)};
      check(cap_code == ec, "R9 decode sweep", cap_code, ec);
      check(cap_chg == 1, "R10 sweep changed", cap_chg, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule